// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels and turns their expiry events into interrupt lines. Each channel delivers a one-cycle fire pulse together with its settings: a 5-bit destination line number, a level/edge selector and a channel enable. A channel in level mode latches a status bit on fire and holds its line high until software clears the bit with a write-one-to-clear strobe. A channel in edge mode leaves its status bit at zero and pulses its line for a single cycle. A global enable gates every channel.

A legacy replacement switch overrides the destination of the two lowest channels: channel 0 goes to line 0 and channel 1 to line 8. The same switch blocks an external real-time-clock interrupt level that normally passes through to line 8. The block keeps sampling that level while it is blocked, so line 8 shows the current value again as soon as the switch is turned off. When several sources land on the same line, they are ORed together. The status vector is read back alongside the lines.

Top module: `timer_irq_router`

## Requirements
- R1: While synchronous reset is held, and on the first cycle after it, every status bit is 0 and every interrupt line is low.
- R2: A fire on an enabled channel in level mode (level_mode bit = 1) sets that channel's status bit on the next clock edge, and its line stays high until the bit is cleared.
- R3: A fire on an enabled channel in edge mode (level_mode bit = 0) leaves the status bit at 0 and raises the channel's line for exactly one cycle.
- R4: When the channel enable or global_en is 0, that channel's status bit goes to 0 and its line goes low on the next edge, and fires are ignored.
- R5: A cycle with status_clr = 1 and status_clr_mask bit i = 1 clears a set status bit i on the next edge and lowers its line.
- R6: A mask bit of 0 during a clear strobe leaves that status bit and its line unchanged.
- R7: With legacy_en = 0, a channel drives the line whose number is its route field, taken from route_flat bits [5*i+4 : 5*i]; every value 0 to 31 is reachable.
- R8: With legacy_en = 1, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold; higher channels keep their route fields.
- R9: The RTC level input is registered and appears on line 8 one cycle later while legacy_en = 0; while legacy_en = 1 it does not reach line 8.
- R10: When legacy_en returns to 0, line 8 shows the RTC level registered most recently, including changes made while legacy mode was on.
- R11: Sources that target the same line are ORed; the line stays high while any of them is active.
- R12: A fire and a clear strobe for the same level-mode channel in the same cycle leave the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fire | input | N_TIMERS | One-cycle expiry pulse per channel |
| route_flat | input | 5*N_TIMERS | Destination line number per channel, 5 bits each |
| level_mode | input | N_TIMERS | 1 = level (latched status), 0 = edge (one-cycle pulse) |
| chan_en | input | N_TIMERS | Per-channel interrupt enable |
| global_en | input | 1 | Enable for all channels |
| legacy_en | input | 1 | Legacy replacement routing for channels 0 and 1 |
| rtc_level | input | 1 | External real-time-clock interrupt level |
| status_clr | input | 1 | Write-one-to-clear strobe for the status vector |
| status_clr_mask | input | N_TIMERS | Data of the clear write, one bit per channel |
| irq_lines | output | 32 | Routed interrupt lines |
| status | output | N_TIMERS | Status bits of level-mode channels |

## Verification
A status bit that is stuck or lost shows at the ports after one edge. The status readback and the line it feeds disagree with the fire and clear history right away, and a bit that fails to clear leaves its line high for every later check. A pulse register that holds too long shows as a line still high one cycle after an edge-mode fire. A stale registered RTC level shows as line 8 in the wrong state on the first cycle after legacy mode is turned off.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int ROUTE_W   = 5;
    localparam int NUM_LINES = 1 << ROUTE_W;

    typedef logic [ROUTE_W-1:0]   route_t;
    typedef logic [NUM_LINES-1:0] lines_t;

    localparam route_t LEG_ROUTE_CH0 = route_t'(0);
    localparam route_t LEG_ROUTE_CH1 = route_t'(8);
    localparam route_t RTC_ROUTE     = route_t'(8);

    // Per-channel control presented to the channel state machine.
    typedef struct packed {
        logic fire;
        logic level;
        logic en;
        logic clr;
    } chan_ctl_t;

    // Per-channel registered state.
    typedef struct packed {
        logic status;
        logic pulse;
    } chan_st_t;

    // Destination line after applying legacy replacement routing.
    function automatic route_t pick_route(input int idx, input logic legacy,
                                          input route_t field);
        if (legacy && idx == 0) return LEG_ROUTE_CH0;
        if (legacy && idx == 1) return LEG_ROUTE_CH1;
        return field;
    endfunction

    function automatic lines_t to_onehot(input route_t r);
        lines_t v;
        v    = '0;
        v[r] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
    import tirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_ctl_t ctl,
    input  logic      global_en,
    output chan_st_t  st
);

    logic active;
    assign active = ctl.en & global_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!active) begin
            st <= '0;
        end else begin
            st.pulse <= ctl.fire & ~ctl.level;
            if (ctl.fire)
                st.status <= ctl.level;
            else if (ctl.clr && st.status)
                st.status <= 1'b0;
        end
    end

    assert_level_set_R2: assert property (@(posedge clk) disable iff (rst)
        (active && ctl.fire && ctl.level) |=> (st.status && !st.pulse));

    assert_edge_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (active && ctl.fire && !ctl.level) |=> (st.pulse && !st.status));

    assert_off_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (!active) |=> (!st.status && !st.pulse));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !ctl.fire && ctl.clr) |=> !st.status);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !ctl.fire && !ctl.clr) |=> $stable(st.status));

    assert_fire_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (active && ctl.fire && ctl.level && ctl.clr) |=> st.status);

endmodule

// File: rtl/tirq_map.sv
module tirq_map
    import tirq_pkg::*;
#(
    parameter int N_TIMERS = 3
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                legacy_en,
    input  route_t              routes [N_TIMERS],
    input  logic [N_TIMERS-1:0] act,
    output lines_t              tlines
);

    lines_t hot [N_TIMERS];

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_src
        route_t eff;
        assign eff    = pick_route(i, legacy_en, routes[i]);
        assign hot[i] = act[i] ? to_onehot(eff) : '0;
    end

    always_comb begin
        tlines = '0;
        for (int i = 0; i < N_TIMERS; i++)
            tlines = tlines | hot[i];
    end

    assert_legacy_ch0_R8: assert property (@(posedge clk) disable iff (rst)
        (legacy_en && act[0]) |-> tlines[LEG_ROUTE_CH0]);

    assert_legacy_ch1_R8: assert property (@(posedge clk) disable iff (rst)
        (legacy_en && act[1]) |-> tlines[LEG_ROUTE_CH1]);

    assert_no_phantom_R11: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |-> (tlines == '0));

endmodule

// File: rtl/tirq_rtc.sv
module tirq_rtc (
    input  logic clk,
    input  logic rst,
    input  logic rtc_level,
    input  logic legacy_en,
    output logic rtc_line
);

    logic rtc_q;

    always_ff @(posedge clk) begin
        if (rst) rtc_q <= 1'b0;
        else     rtc_q <= rtc_level;
    end

    assign rtc_line = rtc_q & ~legacy_en;

    assert_rtc_follow_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !legacy_en) |-> (rtc_line == $past(rtc_level)));

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
    import tirq_pkg::*;
#(
    parameter int N_TIMERS = 3
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_TIMERS-1:0]         fire,
    input  logic [N_TIMERS*ROUTE_W-1:0] route_flat,
    input  logic [N_TIMERS-1:0]         level_mode,
    input  logic [N_TIMERS-1:0]         chan_en,
    input  logic                        global_en,
    input  logic                        legacy_en,
    input  logic                        rtc_level,
    input  logic                        status_clr,
    input  logic [N_TIMERS-1:0]         status_clr_mask,
    output logic [NUM_LINES-1:0]        irq_lines,
    output logic [N_TIMERS-1:0]         status
);

    route_t              routes [N_TIMERS];
    logic [N_TIMERS-1:0] act;
    lines_t              tlines;
    logic                rtc_line;

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
        chan_ctl_t ctl;
        chan_st_t  st;

        assign routes[i] = route_flat[i*ROUTE_W +: ROUTE_W];
        assign ctl.fire  = fire[i];
        assign ctl.level = level_mode[i];
        assign ctl.en    = chan_en[i];
        assign ctl.clr   = status_clr & status_clr_mask[i];

        tirq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .global_en (global_en),
            .st        (st)
        );

        assign status[i] = st.status;
        assign act[i]    = st.status | st.pulse;
    end

    tirq_map #(.N_TIMERS(N_TIMERS)) u_map (
        .clk       (clk),
        .rst       (rst),
        .legacy_en (legacy_en),
        .routes    (routes),
        .act       (act),
        .tlines    (tlines)
    );

    tirq_rtc u_rtc (
        .clk       (clk),
        .rst       (rst),
        .rtc_level (rtc_level),
        .legacy_en (legacy_en),
        .rtc_line  (rtc_line)
    );

    always_comb begin
        irq_lines = tlines;
        if (rtc_line) irq_lines[RTC_ROUTE] = 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && irq_lines == '0));

    assert_rtc_restore_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !legacy_en && $past(rtc_level)) |-> irq_lines[RTC_ROUTE]);

endmodule

// File: tb/sim_timer_irq_router.sv
module sim_timer_irq_router;

    localparam int NT = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic [NT-1:0]   fire, level_mode, chan_en, status_clr_mask;
    logic [NT*5-1:0] route_flat;
    logic            global_en, legacy_en, rtc_level, status_clr;
    logic [31:0]     irq_lines;
    logic [NT-1:0]   status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    timer_irq_router #(.N_TIMERS(NT)) u0 (
        .clk(clk), .rst(rst), .fire(fire), .route_flat(route_flat),
        .level_mode(level_mode), .chan_en(chan_en), .global_en(global_en),
        .legacy_en(legacy_en), .rtc_level(rtc_level), .status_clr(status_clr),
        .status_clr_mask(status_clr_mask), .irq_lines(irq_lines), .status(status)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  fire;
        logic [2:0]  lvl;
        logic [2:0]  en;
        logic        gen;
        logic        leg;
        logic        rtc;
        logic        clr;
        logic [2:0]  mask;
        logic [2:0]  exp_st;
        logic [31:0] exp_ln;
    } vec_t;

    // Routes during the table: ch0 -> 3, ch1 -> 5, ch2 -> 5.
    localparam vec_t TBL [20] = '{
        '{8'd2,  3'b001,3'b001,3'b111,1,0,0,0,3'b000,3'b001,32'h0000_0008}, // R2 set
        '{8'd2,  3'b000,3'b000,3'b111,1,0,0,0,3'b000,3'b001,32'h0000_0008}, // R2 hold
        '{8'd6,  3'b000,3'b000,3'b111,1,0,0,1,3'b000,3'b001,32'h0000_0008}, // R6 zero mask
        '{8'd5,  3'b000,3'b000,3'b111,1,0,0,1,3'b001,3'b000,32'h0000_0000}, // R5 clear
        '{8'd3,  3'b010,3'b000,3'b111,1,0,0,0,3'b000,3'b000,32'h0000_0020}, // R3 pulse
        '{8'd3,  3'b000,3'b000,3'b111,1,0,0,0,3'b000,3'b000,32'h0000_0000}, // R3 one cycle
        '{8'd11, 3'b110,3'b110,3'b111,1,0,0,0,3'b000,3'b110,32'h0000_0020}, // R11 shared
        '{8'd11, 3'b000,3'b000,3'b111,1,0,0,1,3'b010,3'b100,32'h0000_0020}, // R11 still held
        '{8'd5,  3'b000,3'b000,3'b111,1,0,0,1,3'b100,3'b000,32'h0000_0000}, // R5
        '{8'd8,  3'b011,3'b011,3'b111,1,1,0,0,3'b000,3'b011,32'h0000_0101}, // R8 legacy
        '{8'd5,  3'b000,3'b000,3'b111,1,1,0,1,3'b011,3'b000,32'h0000_0000}, // R5
        '{8'd9,  3'b000,3'b000,3'b111,1,1,1,0,3'b000,3'b000,32'h0000_0000}, // R9 blocked
        '{8'd10, 3'b000,3'b000,3'b111,1,0,1,0,3'b000,3'b000,32'h0000_0100}, // R10 restore
        '{8'd9,  3'b000,3'b000,3'b111,1,0,0,0,3'b000,3'b000,32'h0000_0000}, // R9 follow
        '{8'd4,  3'b001,3'b001,3'b110,1,0,0,0,3'b000,3'b000,32'h0000_0000}, // R4 chan off
        '{8'd4,  3'b001,3'b001,3'b111,0,0,0,0,3'b000,3'b000,32'h0000_0000}, // R4 global off
        '{8'd2,  3'b001,3'b001,3'b111,1,0,0,0,3'b000,3'b001,32'h0000_0008}, // R2
        '{8'd4,  3'b000,3'b000,3'b110,1,0,0,0,3'b000,3'b000,32'h0000_0000}, // R4 clears
        '{8'd12, 3'b001,3'b001,3'b111,1,0,0,1,3'b001,3'b001,32'h0000_0008}, // R12 fire wins
        '{8'd4,  3'b000,3'b000,3'b111,0,0,0,0,3'b000,3'b000,32'h0000_0000}  // R4
    };

    task automatic check(input int req, input logic [2:0] exp_st, input logic [31:0] exp_ln);
        checks++;
        if (status !== exp_st || irq_lines !== exp_ln) begin
            fails++;
            $display("FAIL R%0d: status=%b lines=%h expected status=%b lines=%h",
                     req, status, irq_lines, exp_st, exp_ln);
        end
    endtask

    task automatic idle_inputs();
        fire = '0; level_mode = '0; chan_en = '1; global_en = 1'b1;
        legacy_en = 1'b0; rtc_level = 1'b0; status_clr = 1'b0; status_clr_mask = '0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        fire = '1; level_mode = '1;
        route_flat = {5'd5, 5'd5, 5'd3};
        @(negedge clk);
        @(negedge clk);
        check(1, 3'b000, 32'h0); // R1 during reset
        fire = '0; level_mode = '0;
        @(negedge clk);
        rst = 1'b0;
        check(1, 3'b000, 32'h0); // R1 quiet before first active edge
        @(negedge clk);
        check(1, 3'b000, 32'h0); // R1 first cycle after reset

        for (int k = 0; k < 20; k++) begin
            fire = TBL[k].fire; level_mode = TBL[k].lvl; chan_en = TBL[k].en;
            global_en = TBL[k].gen; legacy_en = TBL[k].leg; rtc_level = TBL[k].rtc;
            status_clr = TBL[k].clr; status_clr_mask = TBL[k].mask;
            @(negedge clk);
            check(int'(TBL[k].req), TBL[k].exp_st, TBL[k].exp_ln);
        end

        // R7: highest route value reachable, legacy off
        idle_inputs();
        route_flat = {5'd31, 5'd5, 5'd3};
        fire = 3'b100; level_mode = 3'b100;
        @(negedge clk);
        check(7, 3'b100, 32'h8000_0000);
        // R8: legacy leaves channel 2 on its own route, overrides channel 1
        fire = 3'b010; level_mode = 3'b110; legacy_en = 1'b1;
        @(negedge clk);
        check(8, 3'b110, 32'h8000_0100);
        // R7: legacy off again, channel 1 back on route 5
        fire = '0; legacy_en = 1'b0;
        @(negedge clk);
        check(7, 3'b110, 32'h8000_0020);
        // R10: RTC changes while legacy on, seen once legacy drops
        status_clr = 1'b1; status_clr_mask = 3'b110; legacy_en = 1'b1; rtc_level = 1'b1;
        @(negedge clk);
        check(9, 3'b000, 32'h0);
        status_clr = 1'b0; status_clr_mask = '0; legacy_en = 1'b0;
        @(negedge clk);
        check(10, 3'b000, 32'h0000_0100);
        // R11: RTC and a channel both on line 8, channel cleared, RTC keeps it high
        route_flat = {5'd31, 5'd8, 5'd3};
        fire = 3'b010; level_mode = 3'b010;
        @(negedge clk);
        check(11, 3'b010, 32'h0000_0100);
        fire = '0; status_clr = 1'b1; status_clr_mask = 3'b010;
        @(negedge clk);
        check(11, 3'b000, 32'h0000_0100);
        status_clr = 1'b0; rtc_level = 1'b0;
        @(negedge clk);
        check(9, 3'b000, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule